// File: doc/BRIEF.md
# Register-Pair Step Unit with Address Exposure

This block adds or subtracts one from the registers of a small register file. The file holds three 16-bit pairs, named BC, DE and HL. Each pair is made of a high byte and a low byte. A 16-bit step moves a whole pair up or down by one. The unit drives that pair's value onto a 16-bit address bus for one cycle and raises a strobe while it does so.

A strap input picks one of two behaviours for single-register (8-bit) steps:

- **Early behaviour.** The 8-bit step is done by one half of the 16-bit stepping chain. The carry or borrow is kept inside that byte, and the full pair still appears on the address bus.
- **Later behaviour.** The 8-bit step is done by a separate byte adder. The address bus and the strobe stay idle.

The unit accepts one operation on every clock, with no back-pressure. An operation presented at a rising edge shows its effects in the cycle after that edge:

- the address bus carries the pair value from before the step;
- the strobe is high;
- the register outputs already carry the stepped value.

Top module: `pairinc_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, every register reads zero, the strobe is low and the address bus is zero.
- R2: op_code 1 (step up, 16-bit) and op_code 2 (step down, 16-bit) change the pair chosen by reg_sel[2:1] by one, modulo 65536. reg_sel[2:1] = 0 picks BC, 1 picks DE and 2 picks HL; reg_sel[0] is ignored. The two other pairs do not change.
- R3: In both strap settings, a 16-bit step raises addr_strobe in the following cycle. In that same cycle addr_out carries the value the pair held before the step.
- R4: With late_rev = 0, op_code 3 (step up, 8-bit) or op_code 4 (step down, 8-bit) with an odd reg_sel changes only the low byte of the pair. The odd codes are 1 = C, 3 = E and 5 = L. The byte wraps within 8 bits, and the high byte keeps its value.
- R5: With late_rev = 0, an 8-bit step with an even reg_sel changes only the high byte. The even codes are 0 = B, 2 = D and 4 = H. The byte wraps within 8 bits, and the low byte keeps its value.
- R6: With late_rev = 0, an 8-bit step raises the strobe and places the whole pair value from before the step on addr_out.
- R7: With late_rev = 1, an 8-bit step gives the same register result as in R4 and R5. In the following cycle addr_strobe is low and addr_out is zero.
- R8: addr_out is zero in every cycle in which addr_strobe is low.
- R9: op_code 0, op_codes 5 to 7, and reg_sel values 6 and 7 change no register and leave the strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 3 | Operation: 0 none, 1 step up 16-bit, 2 step down 16-bit, 3 step up 8-bit, 4 step down 8-bit |
| reg_sel | input | SEL_W (3) | Register code: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L |
| late_rev | input | 1 | Strap: 1 routes 8-bit steps through the byte adder |
| addr_out | output | 2*HALF_W (16) | Address bus carrying the exposed pair |
| addr_strobe | output | 1 | High in a cycle in which addr_out carries a pair |
| pairs_out | output | NUM_PAIRS*2*HALF_W (48) | Registers: [15:0] BC, [31:16] DE, [47:32] HL, with the high byte above the low byte in each pair |

## Verification
The bench builds the unit with its default parameters: HALF_W = 8 and NUM_PAIRS = 3. With these values every wrap boundary is one step away from the all-zero reset state. A step down from zero reaches 0xFFFF, and a step down on a zero byte reaches 0xFF. This makes it possible to check carry isolation, and a carry that crosses between the halves, without any load path. The three-pair file also leaves the select codes 6 and 7 free, so the bench can check how an out-of-range selection is handled.

// File: rtl/pairinc_pkg.sv
package pairinc_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_UP16   = 3'd1,
    OP_DOWN16 = 3'd2,
    OP_UP8    = 3'd3,
    OP_DOWN8  = 3'd4
  } step_op_e;
endpackage

// File: rtl/pairinc_halfstep.sv
// One byte-wide slice of the pair stepping chain.
module pairinc_halfstep #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         step_i,
  input  logic         down_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (!step_i)     val_o = val_i;
    else if (down_i) val_o = val_i - ONE;
    else             val_o = val_i + ONE;
  end
endmodule

// File: rtl/pairinc_bytealu.sv
// Separate byte adder used for 8-bit steps when the later behaviour is strapped.
module pairinc_bytealu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         down_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign y_o = down_i ? (a_i - ONE) : (a_i + ONE);
endmodule

// File: rtl/pairinc_regfile.sv
// Register pairs, each byte with its own write enable.
module pairinc_regfile #(
  parameter int W  = 8,
  parameter int NP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP-1:0]     wr_hi,
  input  logic [NP-1:0]     wr_lo,
  input  logic [W-1:0]      hi_d,
  input  logic [W-1:0]      lo_d,
  output logic [NP*2*W-1:0] pairs_o
);
  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [W-1:0] hi_q, lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else begin
        if (wr_hi[p]) hi_q <= hi_d;
        if (wr_lo[p]) lo_q <= lo_d;
      end
    end

    assign pairs_o[p*2*W +: 2*W] = {hi_q, lo_q};
  end
endmodule

// File: rtl/pairinc_addrdrive.sv
// Registered address bus: carries the pair for one cycle, zero otherwise.
module pairinc_addrdrive #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expose_i,
  input  logic [AW-1:0] pair_i,
  output logic [AW-1:0] addr_o,
  output logic          strobe_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o   <= '0;
      strobe_o <= 1'b0;
    end else begin
      addr_o   <= expose_i ? pair_i : '0;
      strobe_o <= expose_i;
    end
  end
endmodule

// File: rtl/pairinc_unit.sv
module pairinc_unit
  import pairinc_pkg::*;
#(
  parameter int HALF_W    = 8,
  parameter int NUM_PAIRS = 3,
  parameter int SEL_W     = $clog2(NUM_PAIRS * 2)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    op_code,
  input  logic [SEL_W-1:0]              reg_sel,
  input  logic                          late_rev,
  output logic [2*HALF_W-1:0]           addr_out,
  output logic                          addr_strobe,
  output logic [NUM_PAIRS*2*HALF_W-1:0] pairs_out
);
  localparam int PAIR_W = 2 * HALF_W;
  localparam int PIDX_W = SEL_W - 1;

  // Operand decode
  logic [PIDX_W-1:0] pair_idx;
  logic              low_sel, sel_ok;
  logic              is16, is8, down, early8, late8;

  assign pair_idx = reg_sel[SEL_W-1:1];
  assign low_sel  = reg_sel[0];
  assign sel_ok   = {1'b0, pair_idx} < (PIDX_W + 1)'(NUM_PAIRS);
  assign is16     = sel_ok && (op_code == OP_UP16 || op_code == OP_DOWN16);
  assign is8      = sel_ok && (op_code == OP_UP8  || op_code == OP_DOWN8);
  assign down     = (op_code == OP_DOWN16) || (op_code == OP_DOWN8);
  assign early8   = is8 && !late_rev;
  assign late8    = is8 && late_rev;

  // Selected pair read
  logic [PAIR_W-1:0] cur_pair;
  always_comb begin
    cur_pair = '0;
    for (int p = 0; p < NUM_PAIRS; p++)
      if (PIDX_W'(p) == pair_idx) cur_pair = pairs_out[p*PAIR_W +: PAIR_W];
  end

  logic [HALF_W-1:0] cur_hi, cur_lo;
  assign cur_hi = cur_pair[PAIR_W-1:HALF_W];
  assign cur_lo = cur_pair[HALF_W-1:0];

  // Split stepping chain: the carry crosses the halves only for 16-bit steps
  logic lo_step, lo_carry, hi_step;
  assign lo_step  = is16 || (early8 && low_sel);
  assign lo_carry = lo_step && (down ? (cur_lo == '0) : (&cur_lo));
  assign hi_step  = (is16 && lo_carry) || (early8 && !low_sel);

  logic [HALF_W-1:0] lo_next, hi_next;
  pairinc_halfstep #(.W(HALF_W)) u_lo (
    .val_i(cur_lo), .step_i(lo_step), .down_i(down), .val_o(lo_next)
  );
  pairinc_halfstep #(.W(HALF_W)) u_hi (
    .val_i(cur_hi), .step_i(hi_step), .down_i(down), .val_o(hi_next)
  );

  // Separate byte path for the later strap setting
  logic [HALF_W-1:0] alu_y;
  pairinc_bytealu #(.W(HALF_W)) u_alu (
    .a_i(low_sel ? cur_lo : cur_hi), .down_i(down), .y_o(alu_y)
  );

  // Write-back
  logic [HALF_W-1:0]    hi_d, lo_d;
  logic [NUM_PAIRS-1:0] wr_hi, wr_lo;
  assign hi_d = late8 ? alu_y : hi_next;
  assign lo_d = late8 ? alu_y : lo_next;

  always_comb begin
    for (int p = 0; p < NUM_PAIRS; p++) begin
      wr_hi[p] = (PIDX_W'(p) == pair_idx) && (is16 || (is8 && !low_sel));
      wr_lo[p] = (PIDX_W'(p) == pair_idx) && (is16 || (is8 && low_sel));
    end
  end

  pairinc_regfile #(.W(HALF_W), .NP(NUM_PAIRS)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .hi_d(hi_d), .lo_d(lo_d), .pairs_o(pairs_out)
  );

  // Address bus drive
  pairinc_addrdrive #(.AW(PAIR_W)) u_ad (
    .clk(clk), .rst_n(rst_n), .expose_i(is16 || early8), .pair_i(cur_pair),
    .addr_o(addr_out), .strobe_o(addr_strobe)
  );
endmodule

// File: rtl/pairinc_unit_chk.sv
module pairinc_unit_chk #(
  parameter int HALF_W    = 8,
  parameter int NUM_PAIRS = 3,
  parameter int SEL_W     = $clog2(NUM_PAIRS * 2)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [2:0]                    op_code,
  input logic [SEL_W-1:0]              reg_sel,
  input logic                          late_rev,
  input logic [2*HALF_W-1:0]           addr_out,
  input logic                          addr_strobe,
  input logic [NUM_PAIRS*2*HALF_W-1:0] pairs_out
);
  localparam int PAIR_W = 2 * HALF_W;
  localparam logic [PAIR_W-1:0] ONE = {{(PAIR_W-1){1'b0}}, 1'b1};

  logic bc_sel, bc16, bc_up16, c_early8, any8;
  assign bc_sel   = (reg_sel[SEL_W-1:1] == '0);
  assign bc16     = bc_sel && (op_code == 3'd1 || op_code == 3'd2);
  assign bc_up16  = bc_sel && (op_code == 3'd1);
  assign c_early8 = (reg_sel == SEL_W'(1)) && !late_rev && (op_code == 3'd3 || op_code == 3'd4);
  assign any8     = (op_code == 3'd3 || op_code == 3'd4) && (reg_sel < SEL_W'(NUM_PAIRS * 2));

  // R3
  bc_expose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc16 |=> addr_strobe && addr_out == $past(pairs_out[PAIR_W-1:0]));

  // R2
  bc_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_up16 |=> pairs_out[PAIR_W-1:0] == $past(pairs_out[PAIR_W-1:0]) + ONE);

  // R2
  others_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc16 |=> $stable(pairs_out[NUM_PAIRS*PAIR_W-1:PAIR_W]));

  // R4
  low_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_early8 |=> $stable(pairs_out[PAIR_W-1:HALF_W]) && addr_strobe);

  // R7
  late_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any8 && late_rev) |=> !addr_strobe);

  // R8
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_strobe |-> addr_out == '0);

  // R9
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0) |=> $stable(pairs_out) && !addr_strobe);
endmodule

bind pairinc_unit pairinc_unit_chk #(
  .HALF_W(HALF_W), .NUM_PAIRS(NUM_PAIRS), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/sim_pairinc_unit.sv
module sim_pairinc_unit;
  typedef struct {
    logic        strobe;
    logic [15:0] addr;
    logic [47:0] pairs;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [2:0]  reg_sel = 3'd0;
  logic        late_rev = 1'b0;
  logic [15:0] addr_out;
  logic        addr_strobe;
  logic [47:0] pairs_out;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];
  logic [15:0] model[3];

  always #4 clk = ~clk;  // 125 MHz

  pairinc_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .reg_sel(reg_sel),
    .late_rev(late_rev), .addr_out(addr_out), .addr_strobe(addr_strobe),
    .pairs_out(pairs_out)
  );

  task automatic check(input string tag, input logic ok,
                       input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: present one operation and push the expected result
  task automatic do_op(input logic [2:0] op, input logic [2:0] sel, input string tag);
    exp_t e;
    int  p;
    bit  ok_sel, s16, s8, dn;
    @(negedge clk);
    op_code = op;
    reg_sel = sel;
    p      = int'(sel[2:1]);
    ok_sel = p < 3;
    s16    = ok_sel && (op == 3'd1 || op == 3'd2);
    s8     = ok_sel && (op == 3'd3 || op == 3'd4);
    dn     = (op == 3'd2 || op == 3'd4);
    e.strobe = 1'b0;
    e.addr   = 16'h0000;
    if (s16 || (s8 && !late_rev)) begin
      e.strobe = 1'b1;
      e.addr   = model[p];
    end
    if (s16) model[p] = dn ? model[p] - 16'd1 : model[p] + 16'd1;
    if (s8) begin
      if (sel[0]) model[p][7:0]  = dn ? model[p][7:0] - 8'd1 : model[p][7:0] + 8'd1;
      else        model[p][15:8] = dn ? model[p][15:8] - 8'd1 : model[p][15:8] + 8'd1;
    end
    e.pairs = {model[2], model[1], model[0]};
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag,
              addr_strobe === e.strobe && addr_out === e.addr && pairs_out === e.pairs,
              {addr_strobe, addr_out, pairs_out}, {e.strobe, e.addr, e.pairs});
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1 reset", addr_strobe === 1'b0 && addr_out === 16'h0 && pairs_out === 48'h0,
          {addr_strobe, addr_out, pairs_out}, 65'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", addr_strobe === 1'b0 && addr_out === 16'h0 && pairs_out === 48'h0,
          {addr_strobe, addr_out, pairs_out}, 65'h0);

    // Early behaviour
    do_op(3'd1, 3'd0, "R2 R3 step up BC");
    do_op(3'd2, 3'd2, "R2 R3 DE wraps down to FFFF");
    do_op(3'd1, 3'd3, "R2 DE wraps up to 0000, select bit0 ignored");
    do_op(3'd4, 3'd5, "R4 R6 L borrow stays in low byte");
    do_op(3'd1, 3'd4, "R2 R3 HL carry crosses halves");
    do_op(3'd3, 3'd5, "R4 R6 step up L exposes HL");
    do_op(3'd4, 3'd4, "R5 R6 step down H");
    do_op(3'd4, 3'd4, "R5 H wraps to FF");
    do_op(3'd3, 3'd1, "R4 step up C");
    do_op(3'd0, 3'd0, "R8 R9 no operation");
    do_op(3'd6, 3'd0, "R9 undefined op code");
    do_op(3'd1, 3'd6, "R9 out-of-range select");
    do_op(3'd3, 3'd7, "R9 out-of-range select 8-bit");

    // Later behaviour
    @(negedge clk);
    late_rev = 1'b1;
    do_op(3'd3, 3'd5, "R7 late step up L");
    do_op(3'd4, 3'd0, "R7 late B wraps down");
    do_op(3'd1, 3'd4, "R3 16-bit still exposes in late mode");
    do_op(3'd3, 3'd3, "R7 late step up E");
    do_op(3'd0, 3'd0, "R8 strobe falls");

    @(negedge clk);
    op_code = 3'd0;
    repeat (3) @(negedge clk);

    rst_n = 1'b0;
    #1;
    check("R1 reset mid-run", addr_strobe === 1'b0 && addr_out === 16'h0 && pairs_out === 48'h0,
          {addr_strobe, addr_out, pairs_out}, 65'h0);
    repeat (2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule